// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer

Two 8-bit timer channels, each with its own count register, its own compare (period) register and its own control byte. While a channel runs, its counter advances on every clock cycle in which the shared count-enable input is high. When the count equals the period value, the counter returns to zero, a one-cycle interrupt pulse is raised and the channel's output pin toggles. A channel in continuous mode keeps going after a match. A channel in one-shot mode clears its own run flag on that match.

A channel is started and stopped by writing its run bit, or by a synchronised edge on its trigger input. Each selected trigger edge toggles the run flag. Software picks which edge is used: rising, falling, both, or none. A pair configuration bit fuses the two channels into one 16-bit timer. In that mode channel 0's controls govern the pair, channel 0's carry advances channel 1, and only the full 16-bit match raises an interrupt and toggles an output. That interrupt and output are channel 0's.

Register map (3-bit address): 0 = control of channel 0, 1 = period of channel 0, 2 = count of channel 0, 3 = pair configuration, 4 = control of channel 1, 5 = period of channel 1, 6 = count of channel 1, 7 = reads zero. Control byte: bit 0 = run, bit 1 = one-shot, bits 3:2 = trigger edge select.

Top module: `dual_timer8`

## Requirements
- R1: After reset, every count, period, control field and the pair bit read 0, and both interrupt pulses and both output pins are 0.
- R2: A running channel in continuous mode with period P counts 0,1,…,P,0,… and advances only in cycles where tick_en is 1. The write that sets run does not itself advance the count.
- R3: Each match raises the channel's irq output for exactly the cycle that follows the matching clock edge.
- R4: The channel's output pin toggles on every match.
- R5: In one-shot mode (control bit 1 = 1) the match clears the run bit (control bit 0). The count then stays at 0.
- R6: Writing 0 to the run bit stops the count, and the count then holds its value. Any write to a count address clears that count to 0. The control byte reads back as written.
- R7: Edge select 01 picks rising edges, 10 falling, 11 both, and 00 disables the trigger. Each selected edge toggles the run bit, which changes at the third rising clock edge after the trigger input changes. An edge that is not selected has no effect.
- R8: With pair bit 0 set, the value {count1,count0} counts 0…{period1,period0} as one 16-bit counter under channel 0's run and mode bits. irq[0] and out[0] act only on the combined match, and irq[1] stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count enable, shared by both channels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| trig_in | input | 2 | External trigger input, one per channel |
| irq | output | 2 | One-cycle match interrupt pulse per channel |
| tmr_out | output | 2 | Toggling timer output per channel |

## Verification
A register write takes effect at the clock edge on which it is sampled, so the bench reads the state mid-cycle right after that edge. A counting step, a match pulse and an output toggle are all due one edge after the cycle in which the count equals the period. The bench therefore checks the count as n modulo (P+1), where n is the number of cycles since the start write. A trigger change reaches the run bit at the third rising edge, and the bench samples after the second edge (expecting no change) and after the third (expecting the change). The fused sweep reads both halves of the count in the same cycle and compares them with n modulo the combined period plus one.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int ADDR_W = 3;

    localparam logic [1:0] SLOT_CTRL = 2'd0;
    localparam logic [1:0] SLOT_PER  = 2'd1;
    localparam logic [1:0] SLOT_CNT  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_PAIR = 3'd3;

    typedef struct packed {
        logic [1:0] edge_sel;
        logic       oneshot;
        logic       run;
    } chan_cfg_t;

endpackage

// File: rtl/dtmr_edge.sv
module dtmr_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_in,
    input  logic [1:0] sel,
    output logic       hit
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   prev_d, prev_q;
    logic                   cur;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], sig_in};
        prev_d = sync_q[SYNC_STAGES-1];
        cur    = sync_q[SYNC_STAGES-1];
        hit    = (sel[0] & cur & ~prev_q) | (sel[1] & ~cur & prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/dtmr_cmp.sv
module dtmr_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] per,
    output logic         eq,
    output logic         all_ones,
    output logic [W-1:0] inc
);
    always_comb begin
        eq       = (cnt == per);
        all_ones = &cnt;
        inc      = cnt + 1'b1;
    end
endmodule

// File: rtl/dual_timer8.sv
module dual_timer8
    import dtmr_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic [1:0]        trig_in,
    output logic [1:0]        irq,
    output logic [1:0]        tmr_out
);
    localparam int NCH = 2;
    localparam int CFG_W = $bits(chan_cfg_t);

    typedef struct packed {
        logic [NCH-1:0][W-1:0] cnt;
        logic [NCH-1:0][W-1:0] per;
        chan_cfg_t [NCH-1:0]   cfg;
        logic                  fused;
        logic [NCH-1:0]        irq;
        logic [NCH-1:0]        tout;
    } state_t;

    state_t st_d, st_q;

    logic [NCH-1:0]        hit, eq, all_ones;
    logic [NCH-1:0][W-1:0] inc;

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        dtmr_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_in (trig_in[gi]),
            .sel    (st_q.cfg[gi].edge_sel),
            .hit    (hit[gi])
        );
        dtmr_cmp #(.W(W)) i_cmp (
            .cnt      (st_q.cnt[gi]),
            .per      (st_q.per[gi]),
            .eq       (eq[gi]),
            .all_ones (all_ones[gi]),
            .inc      (inc[gi])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = '0;

        // counting
        if (!st_q.fused) begin
            for (int i = 0; i < NCH; i++) begin
                if (st_q.cfg[i].run && tick_en) begin
                    if (eq[i]) begin
                        st_d.cnt[i]  = '0;
                        st_d.irq[i]  = 1'b1;
                        st_d.tout[i] = ~st_q.tout[i];
                        if (st_q.cfg[i].oneshot) st_d.cfg[i].run = 1'b0;
                    end else begin
                        st_d.cnt[i] = inc[i];
                    end
                end
            end
        end else if (st_q.cfg[0].run && tick_en) begin
            if (eq[0] && eq[1]) begin
                st_d.cnt     = '0;
                st_d.irq[0]  = 1'b1;
                st_d.tout[0] = ~st_q.tout[0];
                if (st_q.cfg[0].oneshot) st_d.cfg[0].run = 1'b0;
            end else begin
                st_d.cnt[0] = inc[0];
                if (all_ones[0]) st_d.cnt[1] = inc[1];
            end
        end

        // trigger edges toggle the run flag
        for (int i = 0; i < NCH; i++) begin
            if (hit[i]) st_d.cfg[i].run = ~st_q.cfg[i].run;
        end

        // software writes take priority
        if (reg_we) begin
            if (reg_addr == ADDR_PAIR) begin
                st_d.fused = reg_wdata[0];
            end else begin
                case (reg_addr[1:0])
                    SLOT_CTRL: st_d.cfg[reg_addr[2]] = chan_cfg_t'(reg_wdata[CFG_W-1:0]);
                    SLOT_PER:  st_d.per[reg_addr[2]] = reg_wdata;
                    SLOT_CNT:  st_d.cnt[reg_addr[2]] = '0;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_PAIR) begin
            reg_rdata[0] = st_q.fused;
        end else begin
            case (reg_addr[1:0])
                SLOT_CTRL: reg_rdata[CFG_W-1:0] = st_q.cfg[reg_addr[2]];
                SLOT_PER:  reg_rdata = st_q.per[reg_addr[2]];
                SLOT_CNT:  reg_rdata = st_q.cnt[reg_addr[2]];
                default:   reg_rdata = '0;
            endcase
        end
        irq     = st_q.irq;
        tmr_out = st_q.tout;
    end

    for (genvar ai = 0; ai < NCH; ai++) begin : g_ast
        AST_IRQ_TOGGLES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.irq[ai] |-> (st_q.tout[ai] != $past(st_q.tout[ai]))); // R4
    end

    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq[0] && st_q.cfg[0].oneshot && !$past(reg_we) && !$past(hit[0]))
            |-> !st_q.cfg[0].run); // R5

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(st_q.cfg[0].run) && !$past(reg_we)) |-> $stable(st_q.cnt[0])); // R6

    AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick_en) && !$past(reg_we)) |-> $stable(st_q.cnt[0])); // R2

    AST_FUSED_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fused && $past(st_q.fused)) |-> !st_q.irq[1]); // R8

endmodule

// File: tb/test_dual_timer8.sv
module test_dual_timer8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] trig_in = '0;
    logic [1:0] irq;
    logic [1:0] tmr_out;

    int nchecks = 0;
    int nerr = 0;
    bit done = 1'b0;
    logic eo0 = 1'b0;

    always #4 clk = ~clk;

    dual_timer8 i_dual_timer8 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .trig_in(trig_in), .irq(irq), .tmr_out(tmr_out)
    );

    task automatic chk(input string what, input int got, input int exp);
        nchecks++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s: got=%0d expected=%0d at %0t", what, got, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a; #1; v = int'(reg_rdata);
    endtask

    task automatic cyc();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #(64'd8 * 64'd200000);
        if (!done) begin
            nchecks++; nerr++;
            $display("FAIL watchdog: got=1 expected=0");
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end

    initial begin
        int v, v2, k, nmax;
        bit m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) begin rd(3'(a), v); chk("R1 reg after reset", v, 0); end
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 out after reset", int'(tmr_out), 0);

        // R2/R3/R4/R6 continuous sweep over small periods on channel 0
        for (int p = 0; p < 7; p++) begin
            wr(1, 8'(p)); wr(2, 0); wr(0, 8'h01);
            nmax = 3 * (p + 1) + 1;
            for (int n = 0; n <= nmax; n++) begin
                @(negedge clk);
                m = (n > 0) && (n % (p + 1) == 0);
                if (m) eo0 = ~eo0;
                rd(2, v);
                chk("R2 count", v, n % (p + 1));
                chk("R3 irq pulse", int'(irq[0]), int'(m));
                chk("R4 out toggle", int'(tmr_out[0]), int'(eo0));
            end
            wr(0, 8'h00);
            k = (nmax + 1) % (p + 1);
            m = (k == 0);
            if (m) eo0 = ~eo0;
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                rd(2, v);
                chk("R6 stopped count holds", v, k);
                chk("R3 irq after stop", int'(irq[0]), (j == 0) ? int'(m) : 0);
                chk("R4 out after stop", int'(tmr_out[0]), int'(eo0));
            end
        end

        // R2 tick_en gating
        wr(1, 8'd9); wr(2, 0); wr(0, 8'h01);
        @(negedge clk); tick_en = 1'b0;
        for (int j = 0; j < 5; j++) begin cyc(); rd(2, v); chk("R2 no advance without tick_en", v, 0); end
        tick_en = 1'b1;
        cyc(); rd(2, v); chk("R2 advance with tick_en", v, 1);
        wr(0, 8'h00);

        // R5 one-shot
        wr(1, 8'd3); wr(2, 0); wr(0, 8'h03);
        rd(0, v); chk("R6 control readback", v, 3);
        for (int n = 0; n <= 8; n++) begin
            @(negedge clk);
            if (n == 4) eo0 = ~eo0;
            rd(2, v); rd(0, v2);
            chk("R5 one-shot count", v, (n < 4) ? n : 0);
            chk("R5 one-shot run bit", v2 & 1, (n < 4) ? 1 : 0);
            chk("R3 one-shot irq", int'(irq[0]), (n == 4) ? 1 : 0);
            chk("R4 one-shot out", int'(tmr_out[0]), int'(eo0));
        end

        // R7 trigger edges on channel 1
        wr(5, 8'd200); wr(6, 0); wr(4, 8'h04);
        @(negedge clk); trig_in[1] = 1'b1;
        cyc(); rd(4, v); chk("R7 rise edge1 no run", v & 1, 0);
        cyc(); rd(4, v); chk("R7 rise edge2 no run", v & 1, 0);
        cyc(); rd(4, v); chk("R7 rise edge3 run", v & 1, 1);
        rd(6, v); chk("R7 count at start", v, 0);
        cyc(); rd(6, v); chk("R7 count runs", v, 1);
        trig_in[1] = 1'b0;
        repeat (5) cyc();
        rd(4, v); chk("R7 falling ignored when rising picked", v & 1, 1);
        wr(4, 8'h0D);
        @(negedge clk); trig_in[1] = 1'b1;
        cyc(); cyc(); rd(4, v); chk("R7 both edge2 still run", v & 1, 1);
        cyc(); rd(4, v); chk("R7 both rising stops", v & 1, 0);
        trig_in[1] = 1'b0;
        cyc(); cyc(); cyc(); rd(4, v); chk("R7 both falling starts", v & 1, 1);
        wr(4, 8'h00);
        @(negedge clk); trig_in[1] = 1'b1;
        repeat (5) cyc();
        trig_in[1] = 1'b0;
        repeat (5) cyc();
        rd(4, v); chk("R7 disabled trigger ignored", v & 1, 0);
        wr(4, 8'h08);
        @(negedge clk); trig_in[1] = 1'b1;
        repeat (5) cyc();
        rd(4, v); chk("R7 rising ignored when falling picked", v & 1, 0);
        trig_in[1] = 1'b0;
        cyc(); cyc(); rd(4, v); chk("R7 falling edge2 no run", v & 1, 0);
        cyc(); rd(4, v); chk("R7 falling edge3 run", v & 1, 1);
        wr(4, 8'h00);
        chk("R4 ch1 out untouched", int'(tmr_out[1]), 0);

        // R8 fused 16-bit mode, period 0x0103
        wr(3, 8'h01); rd(3, v); chk("R8 pair bit readback", v, 1);
        wr(1, 8'h03); wr(5, 8'h01); wr(2, 0); wr(6, 0); wr(0, 8'h01);
        for (int n = 0; n <= 600; n++) begin
            @(negedge clk);
            m = (n > 0) && (n % 260 == 0);
            if (m) eo0 = ~eo0;
            rd(2, v); rd(6, v2);
            chk("R8 combined count", v2 * 256 + v, n % 260);
            chk("R8 irq0 combined match", int'(irq[0]), int'(m));
            chk("R8 irq1 quiet", int'(irq[1]), 0);
            chk("R8 out0", int'(tmr_out[0]), int'(eo0));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end
endmodule